// File: doc/BRIEF.md
# 32-Line GPIO Controller with Edge Interrupts

This block is a general-purpose I/O peripheral for up to 32 lines, reached through a plain word-wide register bus with an address, a write strobe, write data and combinational read data. For each line, software sets whether it drives or listens, whether it drives push-pull or open-drain, and what value it drives. Pad inputs pass through a synchronizer, and a per-line input enable gates them before they reach software or the edge logic.

Every gated input line has an edge detector. Its per-line mode bit chooses whether only falling edges count or both edges count. A detected edge latches a pending bit that software clears by writing one to it. A mask register selects which pending bits drive the single interrupt output. Register bit positions run opposite to line numbers: line n sits at register bit 31-n.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0, every pad output enable is 0 and the interrupt output is 0.
- R2: Line n corresponds to register bit 31-n in every register. It drives `pad_out[n]` and `pad_oe[n]` and is sampled from `pad_in[n]`, so line 0 is bit 31.
- R3: A direction bit of 1 (offset 0x00) makes the line an output. With open-drain off, `pad_oe` is 1 and `pad_out` follows the output latch. A direction bit of 0 keeps `pad_oe` at 0.
- R4: When the open-drain bit (offset 0x04) is 1 on an output line, `pad_oe` is 1 only while the latch holds 0. While the latch holds 1, the pad is released (`pad_oe` = 0).
- R5: A write to the data register (offset 0x08) loads all 32 latch bits, including those of input lines. The stored value appears on the pad once the line turns into an output.
- R6: Reading offset 0x08 returns the latch bit for output lines and the synchronized, gated pad value for input lines.
- R7: An input line reads 0 unless its input-enable bit (offset 0x18) is 1. A pad change first shows in the data register after the second rising clock edge.
- R8: With the edge-mode bit (offset 0x14) at 0, both a rising and a falling edge of the gated input set the line's event bit (offset 0x0C). The bit reads 1 after the third clock edge following the pad change.
- R9: With the edge-mode bit at 1, only a falling edge sets the event bit, and a rising edge leaves it unchanged.
- R10: Writing 1 to an event bit clears it. Writing 0 leaves it unchanged.
- R11: An edge whose event-setting clock edge coincides with a write-one clear of the same bit leaves the event bit set.
- R12: The interrupt output is 1 exactly when the bitwise AND of the event register and the mask register (offset 0x10, 1 = enabled) is nonzero.
- R13: The direction, open-drain, mask, edge-mode and input-enable registers read back the value last written. Offsets outside the seven registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 32 | Pad input value, indexed by line |
| pad_out | output | 32 | Pad output value, indexed by line |
| pad_oe | output | 32 | Pad output enable, indexed by line |
| irq | output | 1 | Interrupt output, active high |

## Verification
The edge logic is exercised with rising-only, falling-only and alternating pad patterns on one line. These patterns are run in both edge modes, which separates the falling-only decode from the both-edge decode. Data reads are tried with mixed direction masks, with input enable off and then on. A single-line pad change is placed against a known cycle count to pin the synchronizer latency. A clear write is timed to land on the same clock edge as a falling edge, which tells a set-priority design from a clear-priority one. Asymmetric data patterns such as lines 0 and 1 alone detect a wrong bit order.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

   // Byte offsets of the register slots
   typedef enum logic [4:0] {
      OFS_DIR  = 5'h00,
      OFS_ODRN = 5'h04,
      OFS_DATA = 5'h08,
      OFS_EVT  = 5'h0C,
      OFS_MASK = 5'h10,
      OFS_EDGE = 5'h14,
      OFS_INEN = 5'h18
   } reg_ofs_e;

   localparam int unsigned MIN_ADDR_W = 5;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] raw_i,
   input  logic [W-1:0] en_i,
   output logic [W-1:0] gated_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_in_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] stg_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stg_q[s] <= '0;
         end else if (s == 0) begin
            stg_q[s] <= raw_i;
         end else begin
            stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign gated_o = stg_q[STAGES-1] & en_i;

   // R7
   sync_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stg_q[STAGES-1] & ~$past(stg_q[STAGES-1]) & ~$past(stg_q[STAGES-2])) == '0));

endmodule

// File: rtl/gpio_evt.sv
module gpio_evt #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] level_i,
   input  logic [W-1:0] fall_only_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] event_o
);

   logic [W-1:0] prev_q;
   logic [W-1:0] ev_q;
   logic [W-1:0] hit;

   for (genvar b = 0; b < W; b++) begin : g_edge
      assign hit[b] = fall_only_i[b] ? (prev_q[b] & ~level_i[b])
                                     : (prev_q[b] ^ level_i[b]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         ev_q   <= '0;
      end else begin
         prev_q <= level_i;
         ev_q   <= (ev_q & ~clr_i) | hit;
      end
   end

   assign event_o = ev_q;

   // R11
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit != '0) |=> ((ev_q & $past(hit)) == $past(hit)));

   // R10
   no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((ev_q & ~$past(ev_q) & ~$past(hit)) == '0));

   // R10
   clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((ev_q & $past(clr_i & ~hit)) == '0));

endmodule

// File: rtl/gpio_pad_map.sv
module gpio_pad_map #(
   parameter int unsigned W     = 32,
   parameter int unsigned LINES = 32
) (
   input  logic [W-1:0]     dir_w,
   input  logic [W-1:0]     odrn_w,
   input  logic [W-1:0]     lat_w,
   input  logic [LINES-1:0] pad_in_i,
   output logic [LINES-1:0] pad_out_o,
   output logic [LINES-1:0] pad_oe_o,
   output logic [W-1:0]     pad_w
);

   for (genvar n = 0; n < LINES; n++) begin : g_line
      localparam int unsigned B = W - 1 - n;
      assign pad_out_o[n] = lat_w[B];
      assign pad_oe_o[n]  = dir_w[B] & ~(odrn_w[B] & lat_w[B]);
      assign pad_w[B]     = pad_in_i[n];
   end

   for (genvar u = 0; u < W - LINES; u++) begin : g_unused
      assign pad_w[u] = 1'b0;
   end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned LINES       = 32,
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [LINES-1:0]  pad_in,
   output logic [LINES-1:0]  pad_out,
   output logic [LINES-1:0]  pad_oe,
   output logic              irq
);
   import gpio_ctrl_pkg::*;

   if (LINES > DATA_W || LINES == 0) begin : g_bad_lines
      $error("gpio_irq_ctrl: LINES must be 1..DATA_W");
   end
   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
      $error("gpio_irq_ctrl: ADDR_W too small for the register map");
   end

   localparam logic [DATA_W-1:0] LINE_MASK = {DATA_W{1'b1}} << (DATA_W - LINES);
   localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR);
   localparam logic [ADDR_W-1:0] A_ODRN = ADDR_W'(OFS_ODRN);
   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
   localparam logic [ADDR_W-1:0] A_EVT  = ADDR_W'(OFS_EVT);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
   localparam logic [ADDR_W-1:0] A_EDGE = ADDR_W'(OFS_EDGE);
   localparam logic [ADDR_W-1:0] A_INEN = ADDR_W'(OFS_INEN);

   logic [DATA_W-1:0] dir_q, odrn_q, lat_q, mask_q, edge_q, inen_q;
   logic [DATA_W-1:0] pad_w, gated_w, evt_w, clr_w, data_view;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         odrn_q <= '0;
         lat_q  <= '0;
         mask_q <= '0;
         edge_q <= '0;
         inen_q <= '0;
      end else if (bus_we) begin
         case (bus_addr)
            A_DIR:   dir_q  <= bus_wdata & LINE_MASK;
            A_ODRN:  odrn_q <= bus_wdata & LINE_MASK;
            A_DATA:  lat_q  <= bus_wdata & LINE_MASK;
            A_MASK:  mask_q <= bus_wdata & LINE_MASK;
            A_EDGE:  edge_q <= bus_wdata & LINE_MASK;
            A_INEN:  inen_q <= bus_wdata & LINE_MASK;
            default: ;
         endcase
      end
   end

   assign clr_w = (bus_we && bus_addr == A_EVT) ? (bus_wdata & LINE_MASK) : '0;

   gpio_pad_map #(.W(DATA_W), .LINES(LINES)) u_pad_map (
      .dir_w     (dir_q),
      .odrn_w    (odrn_q),
      .lat_w     (lat_q),
      .pad_in_i  (pad_in),
      .pad_out_o (pad_out),
      .pad_oe_o  (pad_oe),
      .pad_w     (pad_w)
   );

   gpio_in_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_in_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw_i   (pad_w),
      .en_i    (inen_q),
      .gated_o (gated_w)
   );

   gpio_evt #(.W(DATA_W)) u_evt (
      .clk         (clk),
      .rst_n       (rst_n),
      .level_i     (gated_w),
      .fall_only_i (edge_q),
      .clr_i       (clr_w),
      .event_o     (evt_w)
   );

   assign data_view = (dir_q & lat_q) | (~dir_q & gated_w);

   always_comb begin
      case (bus_addr)
         A_DIR:   bus_rdata = dir_q;
         A_ODRN:  bus_rdata = odrn_q;
         A_DATA:  bus_rdata = data_view;
         A_EVT:   bus_rdata = evt_w;
         A_MASK:  bus_rdata = mask_q;
         A_EDGE:  bus_rdata = edge_q;
         A_INEN:  bus_rdata = inen_q;
         default: bus_rdata = '0;
      endcase
   end

   assign irq = |(evt_w & mask_q);

   function automatic logic [LINES-1:0] to_lines(input logic [DATA_W-1:0] v);
      for (int n = 0; n < LINES; n++) to_lines[n] = v[DATA_W-1-n];
   endfunction

   // R4
   odrn_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe & pad_out & to_lines(odrn_q)) == '0));

   // R3
   input_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe & ~to_lines(dir_q)) == '0));

   // R12
   masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !irq);

endmodule

// File: tb/gpio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_bench;

   localparam logic [4:0] A_DIR = 5'h00, A_ODRN = 5'h04, A_DATA = 5'h08,
                          A_EVT = 5'h0C, A_MASK = 5'h10, A_EDGE = 5'h14, A_INEN = 5'h18;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pad_in = '0;
   logic [31:0] pad_out, pad_oe;
   logic        irq;

   int n_chk = 0;
   int n_err = 0;
   bit cmp_on = 1'b0;

   always #4 clk = ~clk;

   gpio_irq_ctrl u_gpio_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
   );

   // Reference model, all vectors indexed by line number
   logic [31:0] m_dir, m_odrn, m_lat, m_ev, m_mask, m_edge, m_inen;
   logic [31:0] m_s1, m_s2, m_prev, m_g, m_set, m_wl;

   function automatic logic [31:0] flip(input logic [31:0] v);
      logic [31:0] r;
      for (int i = 0; i < 32; i++) r[31-i] = v[i];
      return r;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_dir = '0; m_odrn = '0; m_lat = '0; m_ev = '0; m_mask = '0;
         m_edge = '0; m_inen = '0; m_s1 = '0; m_s2 = '0; m_prev = '0;
      end else begin
         m_g = m_s2 & m_inen;
         for (int l = 0; l < 32; l++)
            m_set[l] = m_edge[l] ? (m_prev[l] && !m_g[l]) : (m_prev[l] != m_g[l]);
         m_wl = flip(bus_wdata);
         if (bus_we) begin
            case (bus_addr)
               A_DIR:  m_dir  = m_wl;
               A_ODRN: m_odrn = m_wl;
               A_DATA: m_lat  = m_wl;
               A_EVT:  m_ev   = m_ev & ~m_wl;
               A_MASK: m_mask = m_wl;
               A_EDGE: m_edge = m_wl;
               A_INEN: m_inen = m_wl;
               default: ;
            endcase
         end
         m_ev   = m_ev | m_set;
         m_prev = m_g;
         m_s2   = m_s1;
         m_s1   = pad_in;
      end
   end

   function automatic logic [31:0] model_read(input logic [4:0] a);
      case (a)
         A_DIR:  return flip(m_dir);
         A_ODRN: return flip(m_odrn);
         A_DATA: return flip((m_dir & m_lat) | (~m_dir & m_s2 & m_inen));
         A_EVT:  return flip(m_ev);
         A_MASK: return flip(m_mask);
         A_EDGE: return flip(m_edge);
         A_INEN: return flip(m_inen);
         default: return '0;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && cmp_on) begin
         chk("R2 R5 pad_out", pad_out, m_lat);
         chk("R3 R4 pad_oe", pad_oe, m_dir & ~(m_odrn & m_lat));
         chk("R12 irq", {31'b0, irq}, {31'b0, |(m_ev & m_mask)});
         chk("R6 R13 rdata", bus_rdata, model_read(bus_addr));
      end
   end

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk); #1;
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(negedge clk); #1;
      bus_we = 1'b0;
   endtask

   task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk); #1;
      bus_addr = a;
      @(negedge clk);
      chk(tag, bus_rdata, exp);
      #1;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic finish_run;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      n_err++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      idle(4);
      rst_n = 1'b1;
      idle(1);
      cmp_on = 1'b1;

      // R1: reset state
      chk("R1 irq", {31'b0, irq}, 32'h0);
      chk("R1 pad_oe", pad_oe, 32'h0);
      rd_chk(A_DIR,  32'h0, "R1 dir");
      rd_chk(A_ODRN, 32'h0, "R1 odrn");
      rd_chk(A_DATA, 32'h0, "R1 data");
      rd_chk(A_EVT,  32'h0, "R1 evt");
      rd_chk(A_MASK, 32'h0, "R1 mask");
      rd_chk(A_EDGE, 32'h0, "R1 edge");
      rd_chk(A_INEN, 32'h0, "R1 inen");

      // R13: read-back and unmapped offset
      wr(A_DIR, 32'hA5A5_0F0F);  rd_chk(A_DIR,  32'hA5A5_0F0F, "R13 dir");
      wr(A_ODRN, 32'h1234_5678); rd_chk(A_ODRN, 32'h1234_5678, "R13 odrn");
      wr(A_MASK, 32'h0F0F_F0F0); rd_chk(A_MASK, 32'h0F0F_F0F0, "R13 mask");
      wr(A_EDGE, 32'h8000_0001); rd_chk(A_EDGE, 32'h8000_0001, "R13 edge");
      wr(5'h1C, 32'hFFFF_FFFF);  rd_chk(5'h1C, 32'h0, "R13 unmapped");
      wr(A_DIR, 0); wr(A_ODRN, 0); wr(A_MASK, 0); wr(A_EDGE, 0);

      // R5 R2 R3: latch loads while input, appears on switch to output
      wr(A_DATA, 32'hC000_0000);
      chk("R5 oe while input", pad_oe, 32'h0);
      wr(A_DIR, 32'hFFFF_FFFF);
      chk("R2 R5 pad_out lines 0,1", pad_out, 32'h0000_0003);
      chk("R3 all driven", pad_oe, 32'hFFFF_FFFF);

      // R4: open-drain releases lines holding 1
      wr(A_ODRN, 32'hFFFF_FFFF);
      chk("R4 open-drain oe", pad_oe, 32'hFFFF_FFFC);
      wr(A_ODRN, 0);

      // R6 R7: mixed direction, gating
      wr(A_DIR, 32'hFFFF_0000);
      pad_in = 32'hFFFF_FFFF;
      idle(3);
      rd_chk(A_DATA, 32'hC000_0000, "R7 gated off");
      wr(A_INEN, 32'hFFFF_FFFF);
      idle(3);
      rd_chk(A_DATA, 32'hC000_FFFF, "R6 merged read");

      // R7: two-edge latency on line 31 (bit 0)
      pad_in[31] = 1'b0;
      @(negedge clk);
      chk("R7 after one edge", bus_rdata, 32'hC000_FFFF);
      @(negedge clk);
      chk("R7 after two edges", bus_rdata, 32'hC000_FFFE);
      #1;
      idle(4);
      wr(A_EVT, 32'hFFFF_FFFF);
      rd_chk(A_EVT, 32'h0, "R10 clear all");

      // R8: both-edge mode on line 20 (bit 11)
      pad_in[20] = 1'b0;
      idle(5);
      wr(A_EVT, 32'hFFFF_FFFF);
      rd_chk(A_EVT, 32'h0, "R10 cleared");
      pad_in[20] = 1'b1;
      idle(4);
      rd_chk(A_EVT, 32'h0000_0800, "R8 rising");
      chk("R12 masked", {31'b0, irq}, 32'h0);
      wr(A_MASK, 32'h0000_0800);
      chk("R12 unmasked", {31'b0, irq}, 32'h1);
      wr(A_EVT, 32'h0);
      rd_chk(A_EVT, 32'h0000_0800, "R10 zero write");
      wr(A_EVT, 32'h0000_0800);
      rd_chk(A_EVT, 32'h0, "R10 one write");
      chk("R12 cleared", {31'b0, irq}, 32'h0);
      pad_in[20] = 1'b0;
      idle(4);
      rd_chk(A_EVT, 32'h0000_0800, "R8 falling");
      wr(A_EVT, 32'h0000_0800);

      // R9: falling-only mode
      wr(A_EDGE, 32'h0000_0800);
      pad_in[20] = 1'b1;
      idle(4);
      rd_chk(A_EVT, 32'h0, "R9 rising ignored");
      pad_in[20] = 1'b0;
      idle(4);
      rd_chk(A_EVT, 32'h0000_0800, "R9 falling");

      // R11: clear lands on the setting edge
      pad_in[20] = 1'b1;
      idle(4);
      pad_in[20] = 1'b0;
      @(negedge clk);
      wr(A_EVT, 32'h0000_0800);
      rd_chk(A_EVT, 32'h0000_0800, "R11 set wins");

      wr(A_EVT, 32'hFFFF_FFFF);
      rd_chk(A_EVT, 32'h0, "R10 final clear");
      chk("R12 final", {31'b0, irq}, 32'h0);
      idle(2);
      finish_run();
   end

endmodule